// File: doc/BRIEF.md
# Physical Register Status and Reclaim Tracker

This block follows the lifetime of every physical register in a renaming pipeline. Each register sits in one of three states: Free, Busy (handed to a producing instruction, result not yet written) or Ready (holds a valid result). Alongside the state, each register records the architectural register it was given to, the producing instruction's identifier, a flag saying whether it is still the current mapping of its architectural register, and a 4-bit count of pending readers. The data values and the rename lookup itself live elsewhere.

The pipeline reports five kinds of event, each on its own valid/tag port: allocation at issue, a reader added at issue, the result written back, a reader finished, and an unmap when a newer register takes over an architectural name. The block answers a single query port with the full record of any tag, and it emits a stream of tags to hand back to the free list. A register is handed back only when it is Ready, holds no pending readers and is no longer mapped. Those three conditions are evaluated on the state as it stands after the current cycle's events, so the tag leaves in the same cycle as the event that completes them.

Top module: `preg_tracker`

## Requirements
- R1: After reset, tags 0 to 31 are Ready (q_state 2), mapped, with zero readers and q_arch equal to the tag; tags 32 to 63 are Free (q_state 0) and unmapped. The state encoding is Free=0, Busy=1, Ready=2.
- R2: An allocation of a Free tag makes it Busy on the next cycle, sets it mapped, clears its reader count and records alloc_arch and alloc_instr. An allocation of a tag that is not Free has no effect.
- R3: A write-back of a Busy tag makes it Ready on the next cycle. A write-back of a Ready tag has no effect. q_ready is high exactly when the queried tag is Ready.
- R4: A reader-add raises the tag's count by one and a reader-done lowers it by one. Both events on the same tag in one cycle leave the count unchanged.
- R5: A reader-add at count 15, or a reader-done at count 0, leaves the count as it was and raises cnt_err for the one cycle after the event.
- R6: An unmap clears the tag's mapped flag. An allocation and an unmap of the same Free tag in one cycle leave it Busy and mapped.
- R7: When a tag is Ready, unmapped and has zero readers after this cycle's events, rel_valid is high and rel_tag names it in that same cycle, and the tag reads Free and unmapped on the next cycle. An unmap of a Ready tag with zero readers is released in the unmap cycle.
- R8: At most one tag is released per cycle, and the lowest waiting tag goes first. The others stay waiting and follow in later cycles in ascending order.
- R9: A Busy tag that is unmapped with zero readers is not released. It is released in the cycle its result is written back.
- R10: An unmapped Ready tag with pending readers is not released. It is released in the cycle its last reader finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation event |
| alloc_tag | input | 6 | Tag being allocated |
| alloc_arch | input | 5 | Architectural register that receives the tag |
| alloc_instr | input | 8 | Identifier of the producing instruction |
| rd_inc_valid | input | 1 | Reader-add event |
| rd_inc_tag | input | 6 | Tag gaining a reader |
| rd_dec_valid | input | 1 | Reader-done event |
| rd_dec_tag | input | 6 | Tag losing a reader |
| wb_valid | input | 1 | Result-written event |
| wb_tag | input | 6 | Tag whose result was written |
| unmap_valid | input | 1 | Unmap event |
| unmap_tag | input | 6 | Tag no longer current for its architectural register |
| query_tag | input | 6 | Tag to report on the q_* outputs |
| q_state | output | 2 | State of queried tag (0 Free, 1 Busy, 2 Ready) |
| q_ready | output | 1 | Queried tag holds valid data |
| q_mapped | output | 1 | Queried tag is a current mapping |
| q_readers | output | 4 | Pending reader count of queried tag |
| q_arch | output | 5 | Architectural register recorded for queried tag |
| q_instr | output | 8 | Producer identifier recorded for queried tag |
| rel_valid | output | 1 | A tag is released this cycle |
| rel_tag | output | 6 | Released tag |
| cnt_err | output | 1 | Reader count overflow or underflow in the previous cycle |

## Verification
The bench sweeps every tag through reset, allocation and write-back, then drives one counter from zero up to 15 and back down. This catches a counter that wraps at 15 or below 0, and one that moves when a reader-add and a reader-done arrive together. It also checks that a Ready tag with zero readers is released in the same cycle it is unmapped: a design that looked only at registered state would release it one cycle late. Three releases are triggered in one cycle by a write-back, an unmap and a last reader-done. A picker that is not lowest-first, that drops a waiting tag, or that treats a Busy or still-read tag as releasable gives a wrong rel_tag sequence.

// File: rtl/preg_pkg.sv
package preg_pkg;

    typedef enum logic [1:0] {
        PR_FREE  = 2'd0,
        PR_BUSY  = 2'd1,
        PR_READY = 2'd2
    } preg_state_e;

endpackage

// File: rtl/preg_rdcnt.sv
module preg_rdcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_pre,
    output logic             err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        cnt_pre = cnt_q;
        err     = 1'b0;
        if (clr) begin
            cnt_pre = '0;
        end else begin
            unique case ({inc, dec})
                2'b10: begin
                    if (cnt_q == CNT_MAX) err = 1'b1;
                    else                  cnt_pre = cnt_q + 1'b1;
                end
                2'b01: begin
                    if (cnt_q == '0) err = 1'b1;
                    else             cnt_pre = cnt_q - 1'b1;
                end
                default: cnt_pre = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_pre;
    end

endmodule

// File: rtl/preg_entry.sv
module preg_entry
    import preg_pkg::*;
#(
    parameter int               ARCH_W     = 5,
    parameter int               INSTR_W    = 8,
    parameter int               CNT_W      = 4,
    parameter bit               INIT_READY = 1'b0,
    parameter logic [ARCH_W-1:0] INIT_ARCH = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_hit,
    input  logic [ARCH_W-1:0]  alloc_arch,
    input  logic [INSTR_W-1:0] alloc_instr,
    input  logic               inc_hit,
    input  logic               dec_hit,
    input  logic               wb_hit,
    input  logic               unmap_hit,
    input  logic               grant,
    output logic               cand,
    output preg_state_e        state_q,
    output logic               mapped_q,
    output logic [ARCH_W-1:0]  arch_q,
    output logic [INSTR_W-1:0] instr_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               cnt_err
);

    preg_state_e      state_pre;
    preg_state_e      state_d;
    logic             mapped_pre;
    logic             mapped_d;
    logic             alloc_ok;
    logic [CNT_W-1:0] cnt_pre;

    preg_rdcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (alloc_ok),
        .inc     (inc_hit),
        .dec     (dec_hit),
        .cnt_q   (cnt_q),
        .cnt_pre (cnt_pre),
        .err     (cnt_err)
    );

    // Transitions: Free -alloc-> Busy -writeback-> Ready -release-> Free
    always_comb begin
        alloc_ok  = 1'b0;
        state_pre = state_q;
        unique case (state_q)
            PR_FREE: begin
                if (alloc_hit) begin
                    state_pre = PR_BUSY;
                    alloc_ok  = 1'b1;
                end
            end
            PR_BUSY: begin
                if (wb_hit) state_pre = PR_READY;
            end
            PR_READY: state_pre = PR_READY;
            default:  state_pre = PR_FREE;
        endcase

        if (alloc_ok)       mapped_pre = 1'b1;
        else if (unmap_hit) mapped_pre = 1'b0;
        else                mapped_pre = mapped_q;

        cand     = (state_pre == PR_READY) && !mapped_pre && (cnt_pre == '0);
        state_d  = grant ? PR_FREE : state_pre;
        mapped_d = grant ? 1'b0 : mapped_pre;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= INIT_READY ? PR_READY : PR_FREE;
            mapped_q <= INIT_READY;
            arch_q   <= INIT_ARCH;
            instr_q  <= '0;
        end else begin
            state_q  <= state_d;
            mapped_q <= mapped_d;
            if (alloc_ok) begin
                arch_q  <= alloc_arch;
                instr_q <= alloc_instr;
            end
        end
    end

endmodule

// File: rtl/preg_pick.sv
module preg_pick #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/preg_tracker.sv
module preg_tracker
    import preg_pkg::*;
#(
    parameter int NUM_PREGS   = 64,
    parameter int NUM_ARCH    = 32,
    parameter int INIT_MAPPED = 32,
    parameter int INSTR_W     = 8,
    parameter int CNT_W       = 4,
    parameter int TAG_W       = $clog2(NUM_PREGS),
    parameter int ARCH_W      = $clog2(NUM_ARCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic [ARCH_W-1:0]  alloc_arch,
    input  logic [INSTR_W-1:0] alloc_instr,
    input  logic               rd_inc_valid,
    input  logic [TAG_W-1:0]   rd_inc_tag,
    input  logic               rd_dec_valid,
    input  logic [TAG_W-1:0]   rd_dec_tag,
    input  logic               wb_valid,
    input  logic [TAG_W-1:0]   wb_tag,
    input  logic               unmap_valid,
    input  logic [TAG_W-1:0]   unmap_tag,
    input  logic [TAG_W-1:0]   query_tag,
    output logic [1:0]         q_state,
    output logic               q_ready,
    output logic               q_mapped,
    output logic [CNT_W-1:0]   q_readers,
    output logic [ARCH_W-1:0]  q_arch,
    output logic [INSTR_W-1:0] q_instr,
    output logic               rel_valid,
    output logic [TAG_W-1:0]   rel_tag,
    output logic               cnt_err
);

    preg_state_e        st   [NUM_PREGS];
    logic               mp   [NUM_PREGS];
    logic [ARCH_W-1:0]  ar   [NUM_PREGS];
    logic [INSTR_W-1:0] ins  [NUM_PREGS];
    logic [CNT_W-1:0]   cnt  [NUM_PREGS];
    logic [NUM_PREGS-1:0] cand;
    logic [NUM_PREGS-1:0] err_v;
    logic                 err_q;

    for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
        localparam bit               IR = (g < INIT_MAPPED);
        localparam logic [ARCH_W-1:0] IA = (g < INIT_MAPPED) ? ARCH_W'(g) : '0;

        preg_entry #(
            .ARCH_W     (ARCH_W),
            .INSTR_W    (INSTR_W),
            .CNT_W      (CNT_W),
            .INIT_READY (IR),
            .INIT_ARCH  (IA)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_hit   (alloc_valid  && (alloc_tag  == TAG_W'(g))),
            .alloc_arch  (alloc_arch),
            .alloc_instr (alloc_instr),
            .inc_hit     (rd_inc_valid && (rd_inc_tag == TAG_W'(g))),
            .dec_hit     (rd_dec_valid && (rd_dec_tag == TAG_W'(g))),
            .wb_hit      (wb_valid     && (wb_tag     == TAG_W'(g))),
            .unmap_hit   (unmap_valid  && (unmap_tag  == TAG_W'(g))),
            .grant       (rel_valid    && (rel_tag    == TAG_W'(g))),
            .cand        (cand[g]),
            .state_q     (st[g]),
            .mapped_q    (mp[g]),
            .arch_q      (ar[g]),
            .instr_q     (ins[g]),
            .cnt_q       (cnt[g]),
            .cnt_err     (err_v[g])
        );
    end

    preg_pick #(.N(NUM_PREGS), .W(TAG_W)) u_pick (
        .req   (cand),
        .found (rel_valid),
        .idx   (rel_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |err_v;
    end

    always_comb begin
        q_state   = st[query_tag];
        q_ready   = (st[query_tag] == PR_READY);
        q_mapped  = mp[query_tag];
        q_readers = cnt[query_tag];
        q_arch    = ar[query_tag];
        q_instr   = ins[query_tag];
        cnt_err   = err_q;
    end

endmodule

// File: rtl/preg_tracker_chk.sv
module preg_tracker_chk #(
    parameter int INSTR_W = 8,
    parameter int CNT_W   = 4,
    parameter int TAG_W   = 6,
    parameter int ARCH_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic [TAG_W-1:0]   alloc_tag,
    input logic [ARCH_W-1:0]  alloc_arch,
    input logic [INSTR_W-1:0] alloc_instr,
    input logic               rd_inc_valid,
    input logic [TAG_W-1:0]   rd_inc_tag,
    input logic               rd_dec_valid,
    input logic [TAG_W-1:0]   rd_dec_tag,
    input logic               wb_valid,
    input logic [TAG_W-1:0]   wb_tag,
    input logic               unmap_valid,
    input logic [TAG_W-1:0]   unmap_tag,
    input logic [TAG_W-1:0]   query_tag,
    input logic [1:0]         q_state,
    input logic               q_ready,
    input logic               q_mapped,
    input logic [CNT_W-1:0]   q_readers,
    input logic [ARCH_W-1:0]  q_arch,
    input logic [INSTR_W-1:0] q_instr,
    input logic               rel_valid,
    input logic [TAG_W-1:0]   rel_tag,
    input logic               cnt_err
);

    assert_alloc_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alloc_valid && alloc_tag == query_tag && q_state == 2'd0) && $stable(query_tag))
        |-> (q_state == 2'd1 && q_mapped && q_readers == '0 && q_instr == $past(alloc_instr)));

    assert_wb_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wb_valid && wb_tag == query_tag && q_state == 2'd1 && q_mapped) && $stable(query_tag))
        |-> q_ready);

    assert_incdec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_inc_valid && rd_dec_valid && rd_inc_tag == query_tag && rd_dec_tag == query_tag
               && !(alloc_valid && alloc_tag == query_tag)) && $stable(query_tag))
        |-> (q_readers == $past(q_readers)));

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |-> $past(rd_inc_valid || rd_dec_valid));

    assert_freed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rel_valid) && query_tag == $past(rel_tag)) |-> (q_state == 2'd0 && !q_mapped));

    assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && $past(rel_valid) && !unmap_valid && !wb_valid && !rd_dec_valid)
        |-> (rel_tag > $past(rel_tag)));

endmodule

bind preg_tracker preg_tracker_chk #(
    .INSTR_W (INSTR_W),
    .CNT_W   (CNT_W),
    .TAG_W   (TAG_W),
    .ARCH_W  (ARCH_W)
) u_chk (.*);

// File: tb/preg_tracker_tb.sv
`timescale 1ns/1ps
module preg_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [5:0] alloc_tag = '0;
    logic [4:0] alloc_arch = '0;
    logic [7:0] alloc_instr = '0;
    logic       rd_inc_valid = 1'b0;
    logic [5:0] rd_inc_tag = '0;
    logic       rd_dec_valid = 1'b0;
    logic [5:0] rd_dec_tag = '0;
    logic       wb_valid = 1'b0;
    logic [5:0] wb_tag = '0;
    logic       unmap_valid = 1'b0;
    logic [5:0] unmap_tag = '0;
    logic [5:0] query_tag = '0;
    logic [1:0] q_state;
    logic       q_ready;
    logic       q_mapped;
    logic [3:0] q_readers;
    logic [4:0] q_arch;
    logic [7:0] q_instr;
    logic       rel_valid;
    logic [5:0] rel_tag;
    logic       cnt_err;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    preg_tracker u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; rd_inc_valid = 0; rd_dec_valid = 0;
        wb_valid = 0; unmap_valid = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic look(input int t);
        query_tag = 6'(t);
        #1;
    endtask

    task automatic inc(input int t);
        rd_inc_valid = 1; rd_inc_tag = 6'(t);
    endtask

    task automatic dec(input int t);
        rd_dec_valid = 1; rd_dec_tag = 6'(t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset sweep
        for (int t = 0; t < 64; t++) begin
            look(t);
            chk("R1 state", q_state, t < 32 ? 2 : 0);
            chk("R1 mapped", q_mapped, t < 32 ? 1 : 0);
            chk("R1 readers", q_readers, 0);
            if (t < 32) chk("R1 arch", q_arch, t);
        end
        chk("R1 no release", rel_valid, 0);

        // R2 allocation sweep
        for (int t = 32; t < 64; t++) begin
            @(negedge clk);
            alloc_valid = 1; alloc_tag = 6'(t);
            alloc_arch = 5'((t * 7) % 32); alloc_instr = 8'((t * 5) % 256);
            step();
            look(t);
            chk("R2 busy", q_state, 1);
            chk("R2 mapped", q_mapped, 1);
            chk("R2 arch", q_arch, (t * 7) % 32);
            chk("R2 instr", q_instr, (t * 5) % 256);
            chk("R3 not ready", q_ready, 0);
        end
        alloc_valid = 1; alloc_tag = 6'd5; alloc_arch = 5'd9; alloc_instr = 8'd77;
        step(); look(5);
        chk("R2 ignore state", q_state, 2);
        chk("R2 ignore arch", q_arch, 5);

        // R3 write-back sweep
        for (int t = 32; t < 50; t++) begin
            wb_valid = 1; wb_tag = 6'(t);
            step(); look(t);
            chk("R3 ready state", q_state, 2);
            chk("R3 ready flag", q_ready, 1);
        end
        wb_valid = 1; wb_tag = 6'd5;
        step(); look(5);
        chk("R3 ignore", q_state, 2);
        chk("R3 ignore mapped", q_mapped, 1);

        // R4 / R5 counter walk on tag 40
        for (int k = 1; k <= 3; k++) begin
            inc(40); step(); look(40);
            chk("R4 inc", q_readers, k);
        end
        inc(40); dec(40); step(); look(40);
        chk("R4 inc+dec hold", q_readers, 3);
        dec(40); step(); look(40);
        chk("R4 dec", q_readers, 2);
        for (int k = 3; k <= 15; k++) begin
            inc(40); step(); look(40);
            chk("R4 inc up", q_readers, k);
            chk("R5 no err", cnt_err, 0);
        end
        inc(40); step(); look(40);
        chk("R5 overflow err", cnt_err, 1);
        chk("R5 overflow hold", q_readers, 15);
        inc(40); dec(40); step(); look(40);
        chk("R4 hold at max", q_readers, 15);
        chk("R5 err one cycle", cnt_err, 0);
        for (int k = 14; k >= 0; k--) begin
            dec(40); step(); look(40);
            chk("R4 dec down", q_readers, k);
        end
        chk("R10 mapped no release", rel_valid, 0);
        dec(40); step(); look(40);
        chk("R5 underflow err", cnt_err, 1);
        chk("R5 underflow hold", q_readers, 0);
        step();
        chk("R5 err cleared", cnt_err, 0);

        // R7 unmap releases same cycle
        unmap_valid = 1; unmap_tag = 6'd0; #1;
        chk("R7 same-cycle valid", rel_valid, 1);
        chk("R7 same-cycle tag", rel_tag, 0);
        step(); look(0);
        chk("R7 freed", q_state, 0);
        chk("R7 unmapped", q_mapped, 0);
        chk("R7 one shot", rel_valid, 0);

        // R6 alloc beats unmap
        alloc_valid = 1; alloc_tag = 6'd0; alloc_arch = 5'd3; alloc_instr = 8'd200;
        unmap_valid = 1; unmap_tag = 6'd0; #1;
        chk("R6 no release", rel_valid, 0);
        step(); look(0);
        chk("R6 busy", q_state, 1);
        chk("R6 mapped", q_mapped, 1);
        unmap_valid = 1; unmap_tag = 6'd0;
        step(); look(0);
        chk("R6 unmap clears", q_mapped, 0);

        // R9 busy unmapped stays
        unmap_valid = 1; unmap_tag = 6'd50; #1;
        chk("R9 no release", rel_valid, 0);
        step(); look(50);
        chk("R9 busy", q_state, 1);
        chk("R9 unmapped", q_mapped, 0);

        // R10 pending reader holds
        inc(12); step();
        unmap_valid = 1; unmap_tag = 6'd12; #1;
        chk("R10 no release", rel_valid, 0);
        step(); look(12);
        chk("R10 still ready", q_state, 2);

        // R8 three releases triggered together: tags 7, 12, 50
        wb_valid = 1; wb_tag = 6'd50;
        unmap_valid = 1; unmap_tag = 6'd7;
        dec(12); #1;
        chk("R8 first valid", rel_valid, 1);
        chk("R8 first tag", rel_tag, 7);
        step();
        chk("R10 second valid", rel_valid, 1);
        chk("R10 second tag", rel_tag, 12);
        step();
        chk("R9 third valid", rel_valid, 1);
        chk("R9 third tag", rel_tag, 50);
        step();
        chk("R8 drained", rel_valid, 0);
        look(7);  chk("R8 freed 7", q_state, 0);
        look(12); chk("R8 freed 12", q_state, 0);
        look(50); chk("R8 freed 50", q_state, 0);

        // R9 busy tag 0 released at its write-back
        wb_valid = 1; wb_tag = 6'd0; #1;
        chk("R9 wb release valid", rel_valid, 1);
        chk("R9 wb release tag", rel_tag, 0);
        step(); look(0);
        chk("R9 wb freed", q_state, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule